// File: doc/BRIEF.md
# T1 In-Band Loop Code Inserter

This block sits in the transmit path of a T1 framer, after the framer has placed the framing bit in the serial stream. When a control register asks for it, the block replaces the outgoing payload with a repeating in-band loopback code. The same register holds two request bits. One selects the five-bit loop-up code and the other selects the three-bit loop-down code. While a code is selected, the framing-bit slot still carries the framer's own bit, and the code overwrites every other slot.

A frame-bit marker and a bit-clock enable come in alongside the serial data. Each enabled clock edge moves one bit: the block samples the inputs and the register at that edge and presents the resulting bit on its output register. Setting both request bits is an illegal configuration. In that case the block forwards normal data and raises a flag that stays high until the configuration is corrected.

Top module: `loopcode_inserter`

## Requirements
- R1: With control bit 1 set and control bit 2 clear, successive enabled bits on the output follow the repeating sequence 0,0,0,0,1, starting from the first 0.
- R2: With control bit 2 set and control bit 1 clear, successive enabled bits follow the repeating sequence 0,0,1, starting from the first 0.
- R3: On a bit whose frame marker is high, the output carries the input bit in place of the code bit. The code position still advances on that bit, so the code resumes where it would have been.
- R4: Each time a request bit changes from 0 to 1, as seen on an enabled bit, the code restarts at its first position. While neither request bit is set, the output equals the input bit.
- R5: When control bits 1 and 2 are both set, the output equals the input bit and the illegal flag is 1. Otherwise the flag is 0.
- R6: The output and the flag change only on enabled edges and hold their value between them. Control bits other than 1 and 2 have no effect.
- R7: The output bit and the flag shown after an enabled edge are computed from the data, marker and control values sampled at that same edge, giving one register of latency.
- R8: A synchronous active-high reset clears the output, the flag and both code positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle enable per transmitted bit |
| frame_mark | input | 1 | High during the framing-bit slot |
| tx_in | input | 1 | Framed serial transmit data |
| ctrl_reg | input | CTRL_W (8) | Control register; bit 1 requests loop-up, bit 2 requests loop-down |
| tx_out | output | 1 | Serial data with loop code inserted |
| illegal_cfg | output | 1 | High while both requests are set |

## Verification
The bench builds the block with its default parameters: an 8-bit control register, request bits at positions 1 and 2, and the code lengths 5 and 3. Because the lengths are co-prime with each other and with the 193-bit frame, a few thousand bits bring the framing slot onto every position of each code. Random gaps in the enable and random toggling of the request bits, including the illegal pairing and the unused register bits, test hold behaviour, restarts and flag timing against a bench model.

// File: rtl/lc_pkg.sv
package lc_pkg;

   typedef enum logic [1:0] {
      LC_PASS = 2'd0,
      LC_UP   = 2'd1,
      LC_DOWN = 2'd2,
      LC_BAD  = 2'd3
   } lc_mode_e;

   function automatic lc_mode_e lc_mode(input logic up, input logic dn);
      case ({dn, up})
         2'b01:   return LC_UP;
         2'b10:   return LC_DOWN;
         2'b11:   return LC_BAD;
         default: return LC_PASS;
      endcase
   endfunction

   function automatic int lc_pw(input int len);
      return (len > 1) ? $clog2(len) : 1;
   endfunction

endpackage

// File: rtl/lc_phase_gen.sv
module lc_phase_gen #(
   parameter int            LEN = 5,
   parameter logic [LEN-1:0] PAT = 5'b00001
) (
   input  logic clk,
   input  logic rst,
   input  logic step,
   input  logic active,
   output logic code_bit
);
   import lc_pkg::*;

   localparam int PW = lc_pw(LEN);
   localparam logic [PW-1:0] LAST = PW'(LEN - 1);

   if (LEN < 1) begin : g_len_chk
      $error("lc_phase_gen: LEN must be at least 1");
   end

   logic [PW-1:0] phase;

   always_ff @(posedge clk) begin
      if (rst)
         phase <= '0;
      else if (step) begin
         if (!active)
            phase <= '0;
         else if (phase == LAST)
            phase <= '0;
         else
            phase <= phase + PW'(1);
      end
   end

   // first transmitted bit is the leftmost pattern bit
   always_comb code_bit = PAT[LAST - phase];

   // R4
   idle_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (step && !active) |=> (phase == '0));

   // R1
   phase_range_chk: assert property (@(posedge clk) disable iff (rst)
      phase <= LAST);

   // R6
   phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(phase));

   // R8
   phase_reset_chk: assert property (@(posedge clk)
      rst |=> (phase == '0));

endmodule

// File: rtl/lc_out_stage.sv
module lc_out_stage (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  lc_pkg::lc_mode_e mode,
   input  logic             frame_mark,
   input  logic             tx_in,
   input  logic             up_bit,
   input  logic             dn_bit,
   output logic             tx_out,
   output logic             illegal
);
   import lc_pkg::*;

   logic nxt_bit;

   always_comb begin
      nxt_bit = tx_in;
      if (!frame_mark) begin
         case (mode)
            LC_UP:   nxt_bit = up_bit;
            LC_DOWN: nxt_bit = dn_bit;
            default: nxt_bit = tx_in;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_out  <= 1'b0;
         illegal <= 1'b0;
      end else if (step) begin
         tx_out  <= nxt_bit;
         illegal <= (mode == LC_BAD);
      end
   end

   // R3
   frame_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (step && frame_mark) |=> (tx_out == $past(tx_in)));

   // R5
   bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (step && mode == LC_BAD) |=> (illegal && tx_out == $past(tx_in)));

   // R4
   pass_chk: assert property (@(posedge clk) disable iff (rst)
      (step && mode == LC_PASS) |=> (!illegal && tx_out == $past(tx_in)));

   // R6
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> ($stable(tx_out) && $stable(illegal)));

   // R8
   out_reset_chk: assert property (@(posedge clk)
      rst |=> (!tx_out && !illegal));

endmodule

// File: rtl/loopcode_inserter.sv
module loopcode_inserter #(
   parameter int                CTRL_W = 8,
   parameter int                UP_POS = 1,
   parameter int                DN_POS = 2,
   parameter int                UP_LEN = 5,
   parameter logic [UP_LEN-1:0] UP_PAT = 5'b00001,
   parameter int                DN_LEN = 3,
   parameter logic [DN_LEN-1:0] DN_PAT = 3'b001
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_en,
   input  logic              frame_mark,
   input  logic              tx_in,
   input  logic [CTRL_W-1:0] ctrl_reg,
   output logic              tx_out,
   output logic              illegal_cfg
);
   import lc_pkg::*;

   localparam int NCODE = 2;
   localparam int MAXL  = (UP_LEN > DN_LEN) ? UP_LEN : DN_LEN;

   if (UP_POS >= CTRL_W || DN_POS >= CTRL_W || UP_POS < 0 || DN_POS < 0) begin : g_pos_chk
      $error("loopcode_inserter: request bit outside control register");
   end
   if (UP_POS == DN_POS) begin : g_dup_chk
      $error("loopcode_inserter: request bits must differ");
   end

   logic     req_up, req_dn;
   lc_mode_e mode;
   logic [NCODE-1:0] act;
   logic [NCODE-1:0] cbit;

   always_comb begin
      req_up = ctrl_reg[UP_POS];
      req_dn = ctrl_reg[DN_POS];
      mode   = lc_mode(req_up, req_dn);
      act    = {req_dn, req_up};
   end

   for (genvar g = 0; g < NCODE; g++) begin : g_code
      localparam int              L = (g == 0) ? UP_LEN : DN_LEN;
      localparam logic [MAXL-1:0] P = (g == 0) ? MAXL'(UP_PAT) : MAXL'(DN_PAT);
      lc_phase_gen #(
         .LEN (L),
         .PAT (P[L-1:0])
      ) u_gen (
         .clk      (clk),
         .rst      (rst),
         .step     (bit_en),
         .active   (act[g]),
         .code_bit (cbit[g])
      );
   end

   lc_out_stage u_out (
      .clk        (clk),
      .rst        (rst),
      .step       (bit_en),
      .mode       (mode),
      .frame_mark (frame_mark),
      .tx_in      (tx_in),
      .up_bit     (cbit[0]),
      .dn_bit     (cbit[1]),
      .tx_out     (tx_out),
      .illegal    (illegal_cfg)
   );

   // R5
   flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (bit_en && !(req_up && req_dn)) |=> !illegal_cfg);

   // R7
   flag_latency_chk: assert property (@(posedge clk) disable iff (rst)
      bit_en |=> (illegal_cfg == ($past(req_up) && $past(req_dn))));

endmodule

// File: tb/sim_loopcode_inserter.sv
module sim_loopcode_inserter;

   logic       clk = 1'b0;
   logic       rst;
   logic       bit_en;
   logic       frame_mark;
   logic       tx_in;
   logic [7:0] ctrl_reg;
   logic       tx_out;
   logic       illegal_cfg;

   always #10 clk = ~clk;

   loopcode_inserter u0 (
      .clk         (clk),
      .rst         (rst),
      .bit_en      (bit_en),
      .frame_mark  (frame_mark),
      .tx_in       (tx_in),
      .ctrl_reg    (ctrl_reg),
      .tx_out      (tx_out),
      .illegal_cfg (illegal_cfg)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int ph_up  = 0;
   int ph_dn  = 0;
   int fpos   = 0;
   logic e_out = 1'b0;
   logic e_ill = 1'b0;
   bit   done  = 1'b0;

   function automatic logic up_code(input int ph);
      return (ph == 4);
   endfunction

   function automatic logic dn_code(input int ph);
      return (ph == 2);
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // one transmitted slot; model updated only on enabled edges
   task automatic step(input logic en, input logic d, input logic [7:0] c, input string req);
      logic fm, up, dn;
      @(negedge clk);
      fm = (fpos == 0);
      bit_en = en; tx_in = d; ctrl_reg = c; frame_mark = fm;
      @(posedge clk);
      #1;
      if (en) begin
         up = c[1]; dn = c[2];
         e_ill = up & dn;
         if (fm || (up == dn))   e_out = d;
         else if (up)            e_out = up_code(ph_up);
         else                    e_out = dn_code(ph_dn);
         ph_up = up ? (ph_up + 1) % 5 : 0;
         ph_dn = dn ? (ph_dn + 1) % 3 : 0;
         fpos  = (fpos + 1) % 193;
      end
      check({req, " data"}, tx_out, e_out);
      check({req, " flag"}, illegal_cfg, e_ill);
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd2151);
      rst = 1'b1; bit_en = 1'b0; frame_mark = 1'b0; tx_in = 1'b0; ctrl_reg = '0;
      repeat (3) @(posedge clk);
      #1;
      // R8 reset state
      check("R8 reset data", tx_out, 1'b0);
      check("R8 reset flag", illegal_cfg, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      // R4 pass-through with no request
      for (int i = 0; i < 8; i++) step(1'b1, i[0], 8'h00, "R4 idle");
      // R1 loop-up code with ones on input
      for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 8'h02, "R1 up");
      // R6 enable low holds output
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 8'h04, "R6 hold");
      // R4 restart: clear then set again mid-pattern
      step(1'b1, 1'b1, 8'h00, "R4 clear");
      for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 8'h02, "R4 restart");
      // R2 loop-down code
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 8'h04, "R2 down");
      // R5 both requests set
      for (int i = 0; i < 5; i++) step(1'b1, i[1], 8'h06, "R5 both");
      step(1'b1, 1'b0, 8'h04, "R5 cleared");
      // R6 unused register bits ignored
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 8'hF9, "R6 other bits");
      // R3 run across frame boundaries with codes active
      while (fpos != 190) step(1'b1, 1'b1, 8'h02, "R3 up frame");
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 8'h02, "R3 frame slot");
      // R7 random mix
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] c;
         c = 8'($urandom);
         if ($urandom % 8 != 0) c[2:1] = (i / 300) % 2 == 0 ? 2'b01 : 2'b10;
         step(($urandom % 4) != 0, 1'($urandom), c, "R7 random");
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule